// File: doc/BRIEF.md
# Charger Status Interrupt Generator

This block watches six synchronized charger condition levels (adapter present, two load-insert detectors, output short, over-temperature and end-of-charge) and turns them into one active-low, open-drain style interrupt line plus a readable status byte and a writable mask byte. The interrupt pin is modeled as an output enable: when `intOe` is high the pad pulls the line low, otherwise the line is released.

Each source has its own triggering rule. Adapter, over-temperature and end-of-charge raise a fixed-length pulse on any change. The two load-insert detectors raise a pulse only when they assert and their status bits stay set until the status byte is read. The output-short condition holds the line low for as long as it lasts. A mask bit silences the pin for its source while the status bit keeps updating. Events arriving while a pulse runs restart its timer, so bursts merge into one longer pulse.

The pulse length is one millisecond derived from the `CLK_HZ` parameter; `PULSE_DIV` divides it for short simulations.

Top module: `chg_irq_gen`

## Requirements
- R1: After reset `intOe` is 0, `statusByte` is 0x00 and `maskByte` is 0x00.
- R2: A change in either direction on source bit 0 (adapter), bit 4 (over-temperature) or bit 5 (end-of-charge) starts a pulse: `intOe` is 1 for exactly PULSE_CYC = CLK_HZ/1000/PULSE_DIV clock cycles.
- R3: Source bits 1 and 2 (load-insert A and B) start a pulse on a 0-to-1 change only; a 1-to-0 change starts none.
- R4: While status bit 3 (output short) is 1 and mask bit 3 is 0, `intOe` is 1 continuously, with no pulse timer involved.
- R5: Status bits 1 and 2 are sticky: set by the rising edge, cleared only by a cycle with `statusRd` high; a rising edge in the same cycle as the read leaves the bit set.
- R6: Status bits 0, 3, 4 and 5 follow their source inputs two clock edges after the input changes; status bits 7:6 read 0.
- R7: A mask bit at the same position as a status bit, written through `maskWe`/`maskWdata` and read back on `maskByte` (bits 7:6 read 0), keeps that source from driving `intOe`; its status bit still updates.
- R8: A qualifying event during an active pulse reloads the timer, so `intOe` stays 1 for PULSE_CYC cycles after the newest event.
- R9: An edge-triggered pulse begins on the third clock edge after the source input changes (two synchronizer stages plus the edge register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 6 | Condition levels: 0 adapter, 1 insert A, 2 insert B, 3 short, 4 over-temperature, 5 end-of-charge |
| statusRd | input | 1 | One-cycle strobe marking a read of the status byte |
| maskWe | input | 1 | Mask write enable |
| maskWdata | input | 8 | Mask write data, bit positions as the status byte |
| statusByte | output | 8 | Status byte |
| maskByte | output | 8 | Mask byte readback |
| intOe | output | 1 | Interrupt pull-down enable (1 drives the line low) |

## Verification
A source change driven just after a clock edge shows on the live status bits and on the short hold after the second edge, and sets a sticky bit and starts a pulse after the third edge; a mask write takes effect after the first edge. The pulse then stays high through the edge PULSE_CYC-1 later and is released one edge after that. Every check is placed on exactly these edges, sampled one time unit after the edge, so a pulse that is one cycle short or long, starts late, or is restarted by a falling insert edge shows as a mismatch.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  localparam int NSRC = 6;
  localparam int SRC_ADAPTER = 0;
  localparam int SRC_INS_A   = 1;
  localparam int SRC_INS_B   = 2;
  localparam int SRC_SHORT   = 3;
  localparam int SRC_OTEMP   = 4;
  localparam int SRC_EOC     = 5;

  typedef enum logic [1:0] {
    TRIG_BOTH  = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_LEVEL = 2'd2
  } trigKind_e;

  function automatic trigKind_e trigOf(input int idx);
    case (idx)
      SRC_INS_A, SRC_INS_B: trigOf = TRIG_RISE;
      SRC_SHORT:            trigOf = TRIG_LEVEL;
      default:              trigOf = TRIG_BOTH;
    endcase
  endfunction

  function automatic bit isSticky(input int idx);
    isSticky = (idx == SRC_INS_A) || (idx == SRC_INS_B);
  endfunction

  // control -> datapath strobes
  typedef struct packed {
    logic clrSticky;
  } dpStrobe_t;

  // datapath -> control event view
  typedef struct packed {
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] fall;
    logic [NSRC-1:0] live;
  } srcEvt_t;
endpackage

// File: rtl/chg_status_dp.sv
module chg_status_dp
  import chg_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcIn,
  input  dpStrobe_t       strobe,
  output srcEvt_t         evt,
  output logic [NSRC-1:0] statusBits
);
  logic [NSRC-1:0] syncA;
  logic [NSRC-1:0] syncB;
  logic [NSRC-1:0] prevB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_comb begin
    evt.live = syncB;
    evt.rise = syncB & ~prevB;
    evt.fall = ~syncB & prevB;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (isSticky(i)) begin : g_sticky
      logic holdQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) holdQ <= 1'b0;
        else       holdQ <= (holdQ & ~strobe.clrSticky) | evt.rise[i];
      end
      assign statusBits[i] = holdQ;
    end else begin : g_live
      assign statusBits[i] = syncB[i];
    end
  end
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
#(
  parameter int PULSE_CYC = 200000
) (
  input  logic            clk,
  input  logic            rstN,
  input  srcEvt_t         evt,
  input  logic            statusRd,
  input  logic            maskWe,
  input  logic [NSRC-1:0] maskWdata,
  output dpStrobe_t       strobe,
  output logic [NSRC-1:0] maskQ,
  output logic            intOe
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [NSRC-1:0]  edgeHit;
  logic [NSRC-1:0]  levelHit;
  logic [CNT_W-1:0] pulseCnt;

  for (genvar i = 0; i < NSRC; i++) begin : g_rule
    if (trigOf(i) == TRIG_BOTH) begin : g_both
      assign edgeHit[i]  = (evt.rise[i] | evt.fall[i]) & ~maskQ[i];
      assign levelHit[i] = 1'b0;
    end else if (trigOf(i) == TRIG_RISE) begin : g_rise
      assign edgeHit[i]  = evt.rise[i] & ~maskQ[i];
      assign levelHit[i] = 1'b0;
    end else begin : g_level
      assign edgeHit[i]  = 1'b0;
      assign levelHit[i] = evt.live[i] & ~maskQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        maskQ <= '0;
    else if (maskWe)  maskQ <= maskWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (|edgeHit)        pulseCnt <= CNT_LOAD;
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
  end

  always_comb begin
    strobe.clrSticky = statusRd;
    intOe = (pulseCnt != '0) | (|levelHit);
  end
endmodule

// File: rtl/chg_irq_gen.sv
module chg_irq_gen
  import chg_irq_pkg::*;
#(
  parameter int CLK_HZ    = 200_000_000,
  parameter int PULSE_DIV = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] srcIn,
  input  logic       statusRd,
  input  logic       maskWe,
  input  logic [7:0] maskWdata,
  output logic [7:0] statusByte,
  output logic [7:0] maskByte,
  output logic       intOe
);
  localparam int PULSE_CYC = CLK_HZ / 1000 / PULSE_DIV;

  dpStrobe_t       strobe;
  srcEvt_t         evt;
  logic [NSRC-1:0] statusBits;
  logic [NSRC-1:0] maskQ;

  chg_status_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .strobe    (strobe),
    .evt       (evt),
    .statusBits(statusBits)
  );

  chg_irq_ctrl #(.PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .statusRd (statusRd),
    .maskWe   (maskWe),
    .maskWdata(maskWdata[NSRC-1:0]),
    .strobe   (strobe),
    .maskQ    (maskQ),
    .intOe    (intOe)
  );

  assign statusByte = {{(8-NSRC){1'b0}}, statusBits};
  assign maskByte   = {{(8-NSRC){1'b0}}, maskQ};
endmodule

// File: rtl/chg_irq_gen_chk.sv
module chg_irq_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       statusRd,
  input logic       maskWe,
  input logic [7:0] maskWdata,
  input logic [7:0] statusByte,
  input logic [7:0] maskByte,
  input logic       intOe
);
  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3] && !maskByte[3]) |-> intOe);

  p_sticky_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[1] && !statusRd) |=> statusByte[1]);

  p_mask_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    maskWe |=> (maskByte[5:0] == $past(maskWdata[5:0])));

  p_pulse_span_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(intOe) && !(statusByte[3] && !maskByte[3])) |=> intOe);
endmodule

bind chg_irq_gen chg_irq_gen_chk u_chk (.*);

// File: tb/chg_irq_gen_test.sv
module chg_irq_gen_test;
  localparam int PCYC = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] srcIn = '0;
  logic       statusRd = 1'b0;
  logic       maskWe = 1'b0;
  logic [7:0] maskWdata = '0;
  logic [7:0] statusByte;
  logic [7:0] maskByte;
  logic       intOe;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chg_irq_gen #(.CLK_HZ(200_000_000), .PULSE_DIV(20000)) uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .statusRd(statusRd),
    .maskWe(maskWe), .maskWdata(maskWdata), .statusByte(statusByte),
    .maskByte(maskByte), .intOe(intOe)
  );

  // {src[5:0], mask[5:0], expStatus[7:0], expIrqAtEdge3, expIrqAfterPulse}
  localparam logic [21:0] VEC [12] = '{
    {6'b000001, 6'b000000, 8'h01, 1'b1, 1'b0},  // R2 adapter on
    {6'b000000, 6'b000000, 8'h00, 1'b1, 1'b0},  // R2 adapter off
    {6'b000010, 6'b000000, 8'h02, 1'b1, 1'b0},  // R3 insert A rise
    {6'b000000, 6'b000000, 8'h00, 1'b0, 1'b0},  // R3 insert A fall silent
    {6'b010000, 6'b000000, 8'h10, 1'b1, 1'b0},  // R2 over-temp on
    {6'b110000, 6'b000000, 8'h30, 1'b1, 1'b0},  // R2 end-of-charge on
    {6'b111000, 6'b000000, 8'h38, 1'b1, 1'b1},  // R4 short held
    {6'b110000, 6'b000000, 8'h30, 1'b0, 1'b0},  // R4 short release
    {6'b010000, 6'b100000, 8'h10, 1'b0, 1'b0},  // R7 masked eoc fall
    {6'b000100, 6'b100000, 8'h04, 1'b1, 1'b0},  // R3 insert B + over-temp fall
    {6'b001000, 6'b001000, 8'h08, 1'b0, 1'b0},  // R7 masked short
    {6'b000000, 6'b000000, 8'h00, 1'b0, 1'b0}   // R6 all clear
  };

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic readStatus();
    statusRd = 1'b1;
    step(1);
    statusRd = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1 intOe", {7'b0, intOe}, 8'h00);
    chk("R1 status", statusByte, 8'h00);
    chk("R1 mask", maskByte, 8'h00);
    rstN = 1'b1;
    step(2);

    for (int v = 0; v < 12; v++) begin
      srcIn     = VEC[v][21:16];
      maskWdata = {2'b11, VEC[v][15:10]};
      maskWe    = 1'b1;
      step(1);
      maskWe = 1'b0;
      chk("R7 mask readback", maskByte, {2'b00, VEC[v][15:10]});
      step(2);
      chk("R6 R5 status after edge 3", statusByte, VEC[v][9:2]);
      chk("R9 R2 R3 R4 irq at edge 3", {7'b0, intOe}, {7'b0, VEC[v][1]});
      step(PCYC - 1);
      chk("R2 irq last pulse cycle", {7'b0, intOe}, {7'b0, VEC[v][1]});
      step(1);
      chk("R2 R4 irq after pulse", {7'b0, intOe}, {7'b0, VEC[v][0]});
      readStatus();
    end

    // R8: retrigger restarts the pulse timer
    srcIn = 6'b000001;
    step(3);
    chk("R8 first pulse", {7'b0, intOe}, 8'h01);
    step(5);
    srcIn = 6'b000000;
    step(3);
    chk("R8 reload", {7'b0, intOe}, 8'h01);
    step(PCYC - 3);
    chk("R8 held past first end", {7'b0, intOe}, 8'h01);
    step(3);
    chk("R8 release", {7'b0, intOe}, 8'h00);

    // R5: read in the same cycle as the rising edge keeps the bit
    srcIn = 6'b000010;
    step(2);
    statusRd = 1'b1;
    step(1);
    statusRd = 1'b0;
    chk("R5 read vs rise", statusByte, 8'h02);
    step(PCYC + 2);
    chk("R5 sticky held", statusByte, 8'h02);
    readStatus();
    chk("R5 cleared by read", statusByte, 8'h00);
    srcIn = 6'b000000;
    step(PCYC + 4);
    chk("R3 fall no pulse", {7'b0, intOe}, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule